// File: doc/BRIEF.md
# Flash Region Protection Controller

This block guards a 256 KB flash array that is shared by two requesters: the processor, and an external debug path of the kind a boundary-scan probe would use. Each request is a read, a page program, a page erase, or an operation on one of the protection bits. The block checks the request against a security bit and sixteen region locks. It then either forwards the request to the flash as a single command strobe or refuses it with a status code. Only one request is in service at a time. Both ports share one sequencer, and the processor has priority.

Region locks block programs and erases in their own 16 KB region and have no effect on reads. The security bit stops the debug path from reading flash. It cannot simply be cleared: a clear request starts a walk that erases every page in ascending order, and the bit drops only when the last page erase finishes. Every protection bit has a saturating change counter. A wear output rises once any counter reaches its rated limit. A boot pin is captured while reset is asserted and selects the memory map with the boot ROM window visible. It has no path to the protection bits.

Both request ports use valid/ready. A request is taken on a clock edge where valid and ready are both high. Ready is low while a request is in service and also while a response waits. When both ports are valid in the same cycle, only the processor port sees ready. A response stays valid, with rdata and status held steady, until its port raises rsp_ready. That port takes no new request before then, and the other port waits as well.

Top module: `flash_guard`

## Requirements
- R1: Synchronous active-high reset clears all sixteen locks, the security bit, every change counter and the wear output, leaves busy low and no response valid, and leaves both ports ready.
- R2: Opcodes are 00 read, 01 page program, 10 page erase, 11 protection-bit operation. Ready is high only when no request is in service and no response is pending, and the processor wins a same-cycle tie. A response stays valid with stable rdata and status until its rsp_ready is high. Status codes are 00 done, 01 lock violation, 10 access denied, 11 bad target.
- R3: A program or erase whose address bits [17:14] index a set lock returns status 01 and sends no flash command.
- R4: Locks never affect reads. A read of a locked region returns the flash word with status 00.
- R5: While the security bit is set, a debug-port read returns status 10 with rdata zero and does not read the flash. A processor read returns the flash word.
- R6: An allowed program or erase issues exactly one fl_cmd_valid strobe with fl_addr = {addr[17:8], 8'h00}. fl_cmd_erase is 1 for an erase. Busy is high for PAGE_LAT cycles, and the response follows.
- R7: Clearing the security bit erases pages 0 through 1023 in ascending order, one strobe every PAGE_LAT cycles, with busy high throughout (1024*PAGE_LAT cycles). The security bit drops only after the last page. Locks are unchanged.
- R8: In a protection-bit operation, addr[4:0] picks the target (0 to 15 a lock, 16 security) and wdata[0] gives the new value (1 set, 0 clear). A change other than a security clear takes PAGE_LAT busy cycles. Targets 17 to 31 return status 11 and change nothing.
- R9: An operation that writes a protection bit to the value it already holds completes with no busy cycle and does not advance that bit's counter.
- R10: Each bit's counter counts real changes and saturates at WEAR_LIMIT (100). wear_flag is high exactly when some counter has reached the limit.
- R11: boot_map_sel takes boot_pin while reset is high and holds that value afterwards. Changing boot_pin never changes boot_map_sel or any protection bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_pin | input | 1 | Boot mode select, captured during reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request ready |
| cpu_req_op | input | 2 | Processor opcode |
| cpu_req_addr | input | 18 | Processor byte address or bit target |
| cpu_req_wdata | input | 32 | Processor program data or bit value |
| cpu_rsp_valid | output | 1 | Response for the processor valid |
| cpu_rsp_ready | input | 1 | Processor accepts response |
| dbg_req_valid | input | 1 | Debug request valid |
| dbg_req_ready | output | 1 | Debug request ready |
| dbg_req_op | input | 2 | Debug opcode |
| dbg_req_addr | input | 18 | Debug byte address or bit target |
| dbg_req_wdata | input | 32 | Debug program data or bit value |
| dbg_rsp_valid | output | 1 | Response for the debug port valid |
| dbg_rsp_ready | input | 1 | Debug accepts response |
| rsp_rdata | output | 32 | Read data of the pending response |
| rsp_status | output | 2 | Status of the pending response |
| fl_rd_en | output | 1 | Flash read enable |
| fl_cmd_valid | output | 1 | Flash page command strobe |
| fl_cmd_erase | output | 1 | Strobe is an erase (else program) |
| fl_addr | output | 18 | Flash address |
| fl_wdata | output | 32 | Flash program data |
| fl_rdata | input | 32 | Flash read data, same cycle |
| lock_bits | output | 16 | Region lock state |
| secure | output | 1 | Security bit state |
| wear_flag | output | 1 | Some counter reached the limit |
| busy | output | 1 | Multi-cycle operation in progress |
| boot_map_sel | output | 1 | Boot ROM window mapped |

## Verification
A wrong lock or security bit appears on the lock_bits and secure pins in the cycle after the update. It also shows in the next affected request: a program strobe that should not appear, or a debug read that returns flash data, becomes visible within one to PAGE_LAT cycles of acceptance. A wrong latency counter or page counter changes the number of busy cycles and the number and order of erase strobes. Those differences are seen as soon as the response arrives, or at the end of a full wipe. A change counter that advances on a no-change operation, or stops at the wrong value, surfaces only on wear_flag. It is seen when the hundredth real change of that bit completes.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_PWRITE = 2'b01,
    OP_PERASE = 2'b10,
    OP_PROT   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_LOCKED = 2'b01,
    ST_DENIED = 2'b10,
    ST_BADSEL = 2'b11
  } status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_EXEC,
    S_WIPE,
    S_RESP
  } state_e;
endpackage

// File: rtl/fg_arbiter.sv
module fg_arbiter
  import fg_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32
) (
  input  logic              idle,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dbg_valid,
  input  logic [1:0]        dbg_op,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic              cpu_ready,
  output logic              dbg_ready,
  output logic              sel_valid,
  output logic              sel_dbg,
  output op_e               sel_op,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [DATA_W-1:0] sel_wdata
);
  // processor port has fixed priority over the debug port
  always_comb begin
    cpu_ready = idle;
    dbg_ready = idle && !cpu_valid;
    sel_valid = cpu_valid || dbg_valid;
    sel_dbg   = !cpu_valid;
    if (cpu_valid) begin
      sel_op    = op_e'(cpu_op);
      sel_addr  = cpu_addr;
      sel_wdata = cpu_wdata;
    end else begin
      sel_op    = op_e'(dbg_op);
      sel_addr  = dbg_addr;
      sel_wdata = dbg_wdata;
    end
  end
endmodule

// File: rtl/fg_prot_bits.sv
module fg_prot_bits #(
  parameter int N_LOCK     = 16,
  parameter int WEAR_LIMIT = 100,
  localparam int NB        = N_LOCK + 1,
  localparam int TGT_W     = $clog2(NB),
  localparam int CNT_W     = $clog2(WEAR_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [TGT_W-1:0]  upd_idx,
  input  logic              upd_val,
  output logic [N_LOCK-1:0] lock_q,
  output logic              secure_q,
  output logic              wear_flag
);
  logic [NB-1:0] bits_w;
  logic [NB-1:0] at_lim;

  for (genvar i = 0; i < NB; i++) begin : g_bit
    logic             b_q;
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        b_q <= 1'b0;
        c_q <= '0;
      end else if (upd_en && upd_idx == TGT_W'(i) && b_q != upd_val) begin
        b_q <= upd_val;
        if (c_q != CNT_W'(WEAR_LIMIT)) c_q <= c_q + 1'b1;
      end
    end
    assign bits_w[i] = b_q;
    assign at_lim[i] = (c_q == CNT_W'(WEAR_LIMIT));
  end

  assign lock_q    = bits_w[N_LOCK-1:0];
  assign secure_q  = bits_w[N_LOCK];
  assign wear_flag = |at_lim;
endmodule

// File: rtl/fg_seq.sv
module fg_seq
  import fg_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 32,
  parameter int N_LOCK    = 16,
  parameter int PAGE_BITS = 8,
  parameter int PAGE_LAT  = 4,
  localparam int LOCK_W   = $clog2(N_LOCK),
  localparam int TGT_W    = $clog2(N_LOCK + 1),
  localparam int PAGE_W   = ADDR_W - PAGE_BITS,
  localparam int LAT_W    = (PAGE_LAT < 2) ? 1 : $clog2(PAGE_LAT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_valid,
  input  logic              sel_dbg,
  input  op_e               sel_op,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [DATA_W-1:0] sel_wdata,
  input  logic [N_LOCK-1:0] lock_q,
  input  logic              secure_q,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic              cpu_rsp_ready,
  input  logic              dbg_rsp_ready,
  output logic              idle,
  output logic              busy,
  output logic              wipe_active,
  output logic              upd_en,
  output logic [TGT_W-1:0]  upd_idx,
  output logic              upd_val,
  output logic              fl_rd_en,
  output logic              fl_cmd_valid,
  output logic              fl_cmd_erase,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  output logic              cpu_rsp_valid,
  output logic              dbg_rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_status
);
  state_e            st_q;
  logic              dbg_q;
  op_e               op_q;
  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  status_e           stat_q;
  logic [TGT_W-1:0]  tgt_q;
  logic              val_q;
  logic [LAT_W-1:0]  cnt_q;

  logic             accept;
  logic             region_locked;
  logic             denied;
  logic [TGT_W-1:0] tgt;
  logic             tgt_ok;
  logic             tgt_cur;
  logic             lat_done;

  assign accept        = (st_q == S_IDLE) && sel_valid;
  assign region_locked = lock_q[sel_addr[ADDR_W-1 -: LOCK_W]];
  assign denied        = sel_dbg && secure_q;
  assign tgt           = sel_addr[TGT_W-1:0];
  assign tgt_ok        = (tgt <= TGT_W'(N_LOCK));
  assign tgt_cur       = (tgt == TGT_W'(N_LOCK)) ? secure_q : lock_q[tgt[LOCK_W-1:0]];
  assign lat_done      = (cnt_q == LAT_W'(PAGE_LAT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      dbg_q   <= 1'b0;
      op_q    <= OP_READ;
      page_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      stat_q  <= ST_OK;
      tgt_q   <= '0;
      val_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (accept) begin
            dbg_q   <= sel_dbg;
            op_q    <= sel_op;
            page_q  <= sel_addr[ADDR_W-1:PAGE_BITS];
            wdata_q <= sel_wdata;
            tgt_q   <= tgt;
            val_q   <= sel_wdata[0];
            cnt_q   <= '0;
            rdata_q <= '0;
            stat_q  <= ST_OK;
            unique case (sel_op)
              OP_READ: begin
                if (denied) stat_q <= ST_DENIED;
                else        rdata_q <= fl_rdata;
                st_q <= S_RESP;
              end
              OP_PWRITE, OP_PERASE: begin
                if (region_locked) begin
                  stat_q <= ST_LOCKED;
                  st_q   <= S_RESP;
                end else begin
                  st_q <= S_EXEC;
                end
              end
              OP_PROT: begin
                if (!tgt_ok) begin
                  stat_q <= ST_BADSEL;
                  st_q   <= S_RESP;
                end else if (tgt_cur == sel_wdata[0]) begin
                  st_q <= S_RESP;
                end else if (tgt == TGT_W'(N_LOCK) && !sel_wdata[0]) begin
                  page_q <= '0;
                  st_q   <= S_WIPE;
                end else begin
                  st_q <= S_EXEC;
                end
              end
            endcase
          end
        end
        S_EXEC: begin
          if (lat_done) st_q <= S_RESP;
          else          cnt_q <= cnt_q + 1'b1;
        end
        S_WIPE: begin
          if (lat_done) begin
            cnt_q <= '0;
            if (&page_q) st_q <= S_RESP;
            else         page_q <= page_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_RESP: begin
          if (dbg_q ? dbg_rsp_ready : cpu_rsp_ready) st_q <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    idle          = (st_q == S_IDLE);
    busy          = (st_q == S_EXEC) || (st_q == S_WIPE);
    wipe_active   = (st_q == S_WIPE);
    fl_cmd_valid  = (cnt_q == '0) &&
                    (((st_q == S_EXEC) && (op_q != OP_PROT)) || (st_q == S_WIPE));
    fl_cmd_erase  = (st_q == S_WIPE) || (op_q == OP_PERASE);
    fl_rd_en      = accept && (sel_op == OP_READ) && !denied;
    fl_addr       = idle ? sel_addr : {page_q, {PAGE_BITS{1'b0}}};
    fl_wdata      = wdata_q;
    upd_en        = lat_done &&
                    (((st_q == S_EXEC) && (op_q == OP_PROT)) || ((st_q == S_WIPE) && (&page_q)));
    upd_idx       = tgt_q;
    upd_val       = val_q;
    cpu_rsp_valid = (st_q == S_RESP) && !dbg_q;
    dbg_rsp_valid = (st_q == S_RESP) && dbg_q;
    rsp_rdata     = rdata_q;
    rsp_status    = stat_q;
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 32,
  parameter int N_LOCK     = 16,
  parameter int PAGE_BITS  = 8,
  parameter int PAGE_LAT   = 4,
  parameter int WEAR_LIMIT = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_pin,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [1:0]        cpu_req_op,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  input  logic              dbg_req_valid,
  output logic              dbg_req_ready,
  input  logic [1:0]        dbg_req_op,
  input  logic [ADDR_W-1:0] dbg_req_addr,
  input  logic [DATA_W-1:0] dbg_req_wdata,
  output logic              dbg_rsp_valid,
  input  logic              dbg_rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_status,
  output logic              fl_rd_en,
  output logic              fl_cmd_valid,
  output logic              fl_cmd_erase,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic [N_LOCK-1:0] lock_bits,
  output logic              secure,
  output logic              wear_flag,
  output logic              busy,
  output logic              boot_map_sel
);
  localparam int TGT_W = $clog2(N_LOCK + 1);

  logic              idle;
  logic              wipe_active;
  logic              sel_valid;
  logic              sel_dbg;
  op_e               sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              upd_en;
  logic [TGT_W-1:0]  upd_idx;
  logic              upd_val;
  logic              boot_q;

  // boot map select is only loaded while reset is held
  always_ff @(posedge clk) begin
    if (rst) boot_q <= boot_pin;
  end
  assign boot_map_sel = boot_q;

  fg_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .idle      (idle),
    .cpu_valid (cpu_req_valid),
    .cpu_op    (cpu_req_op),
    .cpu_addr  (cpu_req_addr),
    .cpu_wdata (cpu_req_wdata),
    .dbg_valid (dbg_req_valid),
    .dbg_op    (dbg_req_op),
    .dbg_addr  (dbg_req_addr),
    .dbg_wdata (dbg_req_wdata),
    .cpu_ready (cpu_req_ready),
    .dbg_ready (dbg_req_ready),
    .sel_valid (sel_valid),
    .sel_dbg   (sel_dbg),
    .sel_op    (sel_op),
    .sel_addr  (sel_addr),
    .sel_wdata (sel_wdata)
  );

  fg_prot_bits #(.N_LOCK(N_LOCK), .WEAR_LIMIT(WEAR_LIMIT)) u_bits (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_val   (upd_val),
    .lock_q    (lock_bits),
    .secure_q  (secure),
    .wear_flag (wear_flag)
  );

  fg_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_LOCK(N_LOCK),
    .PAGE_BITS(PAGE_BITS), .PAGE_LAT(PAGE_LAT)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .sel_valid     (sel_valid),
    .sel_dbg       (sel_dbg),
    .sel_op        (sel_op),
    .sel_addr      (sel_addr),
    .sel_wdata     (sel_wdata),
    .lock_q        (lock_bits),
    .secure_q      (secure),
    .fl_rdata      (fl_rdata),
    .cpu_rsp_ready (cpu_rsp_ready),
    .dbg_rsp_ready (dbg_rsp_ready),
    .idle          (idle),
    .busy          (busy),
    .wipe_active   (wipe_active),
    .upd_en        (upd_en),
    .upd_idx       (upd_idx),
    .upd_val       (upd_val),
    .fl_rd_en      (fl_rd_en),
    .fl_cmd_valid  (fl_cmd_valid),
    .fl_cmd_erase  (fl_cmd_erase),
    .fl_addr       (fl_addr),
    .fl_wdata      (fl_wdata),
    .cpu_rsp_valid (cpu_rsp_valid),
    .dbg_rsp_valid (dbg_rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_status    (rsp_status)
  );
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 32,
  parameter int N_LOCK  = 16,
  localparam int LOCK_W = $clog2(N_LOCK)
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_ready,
  input logic              dbg_req_ready,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_ready,
  input logic              dbg_rsp_valid,
  input logic              dbg_rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [1:0]        rsp_status,
  input logic              fl_cmd_valid,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [N_LOCK-1:0] lock_bits,
  input logic              secure,
  input logic              wear_flag,
  input logic              busy,
  input logic              boot_map_sel,
  input logic              wipe_active
);
  // R3: a page command outside the wipe never targets a locked region
  p_lock_gate_r3: assert property (@(posedge clk) disable iff (rst)
    fl_cmd_valid && !wipe_active |-> !lock_bits[fl_addr[ADDR_W-1 -: LOCK_W]]);

  // R5: a denied debug read carries zero data
  p_deny_zero_r5: assert property (@(posedge clk) disable iff (rst)
    dbg_rsp_valid && rsp_status == 2'b10 |-> rsp_rdata == '0);

  // R7: security only drops at the end of a wipe
  p_wipe_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(secure) |-> $past(wipe_active));

  // R2: no request accepted while busy
  p_busy_ready_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cpu_req_ready && !dbg_req_ready);

  // R2: back-pressure holds the processor response
  p_cpu_hold_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(rsp_rdata) && $stable(rsp_status));

  // R2: back-pressure holds the debug response
  p_dbg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    dbg_rsp_valid && !dbg_rsp_ready |=> dbg_rsp_valid && $stable(rsp_rdata) && $stable(rsp_status));

  // R2: at most one port has a response
  p_one_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_rsp_valid, dbg_rsp_valid}));

  // R11: boot map select never moves outside reset
  p_boot_hold_r11: assert property (@(posedge clk) disable iff (rst)
    $stable(boot_map_sel));

  // R10: saturating counters keep the wear flag up
  p_wear_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    wear_flag |=> wear_flag);
endmodule

bind flash_guard flash_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_LOCK(N_LOCK)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_req_ready (cpu_req_ready),
  .dbg_req_ready (dbg_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_rsp_ready (cpu_rsp_ready),
  .dbg_rsp_valid (dbg_rsp_valid),
  .dbg_rsp_ready (dbg_rsp_ready),
  .rsp_rdata     (rsp_rdata),
  .rsp_status    (rsp_status),
  .fl_cmd_valid  (fl_cmd_valid),
  .fl_addr       (fl_addr),
  .lock_bits     (lock_bits),
  .secure        (secure),
  .wear_flag     (wear_flag),
  .busy          (busy),
  .boot_map_sel  (boot_map_sel),
  .wipe_active   (wipe_active)
);

// File: tb/tb_flash_guard.sv
module tb_flash_guard;
  localparam int LAT    = 4;
  localparam int NPAGES = 1024;
  localparam int LIMIT  = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_pin = 1'b0;
  logic        cpu_req_valid = 1'b0, dbg_req_valid = 1'b0;
  logic [1:0]  cpu_req_op = '0, dbg_req_op = '0;
  logic [17:0] cpu_req_addr = '0, dbg_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0, dbg_req_wdata = '0;
  logic        cpu_rsp_ready = 1'b0, dbg_rsp_ready = 1'b0;
  logic        cpu_req_ready, dbg_req_ready, cpu_rsp_valid, dbg_rsp_valid;
  logic [31:0] rsp_rdata, fl_wdata, fl_rdata;
  logic [1:0]  rsp_status;
  logic        fl_rd_en, fl_cmd_valid, fl_cmd_erase;
  logic [17:0] fl_addr;
  logic [15:0] lock_bits;
  logic        secure, wear_flag, busy, boot_map_sel;

  always #10 clk = ~clk;

  assign fl_rdata = {14'h2B3C, fl_addr ^ 18'h15A5A};

  flash_guard dut (
    .clk(clk), .rst(rst), .boot_pin(boot_pin),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_op(cpu_req_op),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .dbg_req_valid(dbg_req_valid), .dbg_req_ready(dbg_req_ready), .dbg_req_op(dbg_req_op),
    .dbg_req_addr(dbg_req_addr), .dbg_req_wdata(dbg_req_wdata),
    .dbg_rsp_valid(dbg_rsp_valid), .dbg_rsp_ready(dbg_rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
    .fl_rd_en(fl_rd_en), .fl_cmd_valid(fl_cmd_valid), .fl_cmd_erase(fl_cmd_erase),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .lock_bits(lock_bits), .secure(secure), .wear_flag(wear_flag),
    .busy(busy), .boot_map_sel(boot_map_sel)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // bench model of protection state
  logic [15:0] exp_lock = '0;
  logic        exp_sec = 1'b0;
  int          exp_cnt [17];

  // port monitors
  int          n_strobe, n_prog, n_busy, n_rd;
  logic [9:0]  first_page, last_page;
  logic        last_erase, seq_gap;
  logic [1:0]  got_st;
  logic [31:0] got_rd;
  bit          hold_ok;

  always @(negedge clk) begin
    if (busy) n_busy++;
    if (fl_rd_en) n_rd++;
    if (fl_cmd_valid) begin
      if (n_strobe == 0) first_page = fl_addr[17:8];
      else if (fl_addr[17:8] != 10'(last_page + 10'd1)) seq_gap = 1'b1;
      if (!fl_cmd_erase) n_prog++;
      if (fl_addr[7:0] != 8'h00) seq_gap = 1'b1;
      last_page  = fl_addr[17:8];
      last_erase = fl_cmd_erase;
      n_strobe++;
    end
  end

  function automatic logic [31:0] exp_data(input logic [17:0] a);
    return {14'h2B3C, a ^ 18'h15A5A};
  endfunction

  function automatic logic exp_wear();
    for (int i = 0; i < 17; i++) if (exp_cnt[i] >= LIMIT) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic bp);
    @(negedge clk);
    boot_pin = bp;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_lock = '0;
    exp_sec  = 1'b0;
    for (int i = 0; i < 17; i++) exp_cnt[i] = 0;
  endtask

  task automatic issue(input logic dbg, input logic [1:0] op, input logic [17:0] a,
                       input logic [31:0] wd, input int hold);
    @(negedge clk);
    if (dbg) begin
      dbg_req_valid = 1'b1; dbg_req_op = op; dbg_req_addr = a; dbg_req_wdata = wd;
    end else begin
      cpu_req_valid = 1'b1; cpu_req_op = op; cpu_req_addr = a; cpu_req_wdata = wd;
    end
    n_strobe = 0; n_prog = 0; n_busy = 0; n_rd = 0; seq_gap = 1'b0;
    #1;
    while (!(dbg ? dbg_req_ready : cpu_req_ready)) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    dbg_req_valid = 1'b0;
    while (!(dbg ? dbg_rsp_valid : cpu_rsp_valid)) @(negedge clk);
    got_st  = rsp_status;
    got_rd  = rsp_rdata;
    hold_ok = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!(dbg ? dbg_rsp_valid : cpu_rsp_valid) || rsp_status !== got_st || rsp_rdata !== got_rd)
        hold_ok = 1'b0;
    end
    if (dbg) dbg_rsp_ready = 1'b1; else cpu_rsp_ready = 1'b1;
    @(negedge clk);
    dbg_rsp_ready = 1'b0;
    cpu_rsp_ready = 1'b0;
  endtask

  task automatic run_op(input logic dbg, input logic [1:0] op, input logic [17:0] a,
                        input logic [31:0] wd, input int hold);
    logic [1:0]  es;
    logic [31:0] ed;
    int          eb, estr, tgt;
    logic        cur, chg;
    string       tag;
    es = 2'b00; ed = '0; eb = 0; estr = 0; chg = 1'b0; tgt = int'(a[4:0]);
    case (op)
      2'd0: begin
        tag = "R4 R5 read";
        if (dbg && exp_sec) es = 2'b10; else ed = exp_data(a);
      end
      2'd1, 2'd2: begin
        tag = "R3 R6 page op";
        if (exp_lock[a[17:14]]) es = 2'b01; else begin eb = LAT; estr = 1; end
      end
      default: begin
        tag = "R8 R9 bit op";
        if (tgt > 16) es = 2'b11;
        else begin
          cur = (tgt == 16) ? exp_sec : exp_lock[tgt];
          if (cur != wd[0]) begin
            chg = 1'b1;
            if (tgt == 16 && !wd[0]) begin eb = LAT * NPAGES; estr = NPAGES; tag = "R7 wipe"; end
            else eb = LAT;
          end
        end
      end
    endcase
    issue(dbg, op, a, wd, hold);
    if (chg) begin
      if (tgt == 16) exp_sec = wd[0]; else exp_lock[tgt] = wd[0];
      if (exp_cnt[tgt] < LIMIT) exp_cnt[tgt]++;
    end
    check({tag, " status"}, 32'(got_st), 32'(es));
    check({tag, " rdata"}, got_rd, ed);
    check({tag, " busy cycles"}, n_busy, eb);
    check({tag, " strobes"}, n_strobe, estr);
    if (op == 2'd0) check("R5 flash read enable", n_rd, (es == 2'b00) ? 1 : 0);
    if (estr == 1) begin
      check("R6 page address", 32'(last_page), 32'(a[17:8]));
      check("R6 erase kind", 32'(last_erase), (op == 2'd2) ? 1 : 0);
    end
    if (hold > 0) check("R2 response held", 32'(hold_ok), 1);
    check({tag, " lock bits"}, 32'(lock_bits), 32'(exp_lock));
    check({tag, " secure"}, 32'(secure), 32'(exp_sec));
    check("R10 wear flag", 32'(wear_flag), 32'(exp_wear()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0);
    @(negedge clk);
    // R1 reset state
    check("R1 locks", 32'(lock_bits), 0);
    check("R1 secure", 32'(secure), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 wear", 32'(wear_flag), 0);
    check("R1 no response", 32'({cpu_rsp_valid, dbg_rsp_valid}), 0);
    check("R1 ready", 32'({cpu_req_ready, dbg_req_ready}), 32'h3);
    check("R11 boot sel low", 32'(boot_map_sel), 0);

    // R2 tie: processor wins
    @(negedge clk);
    cpu_req_valid = 1'b1; dbg_req_valid = 1'b1;
    #1;
    check("R2 tie cpu ready", 32'(cpu_req_ready), 1);
    check("R2 tie dbg ready", 32'(dbg_req_ready), 0);
    cpu_req_valid = 1'b0; dbg_req_valid = 1'b0;

    // random mix; security set halfway
    for (int i = 0; i < 200; i++) begin
      int r;
      logic d;
      logic [17:0] a;
      if (i == 100) run_op(1'b0, 2'd3, 18'd16, 32'd1, 0);
      r = int'($urandom % 8);
      d = 1'($urandom % 2);
      a = 18'($urandom);
      if (r < 3)      run_op(d, 2'd0, a, $urandom, int'($urandom % 3));
      else if (r < 5) run_op(d, 2'd1, a, $urandom, 0);
      else if (r < 7) run_op(d, 2'd2, a, $urandom, 0);
      else            run_op(d, 2'd3, 18'($urandom % 16), 32'($urandom % 2), 0);
    end

    // R5 directed with security set
    check("R5 secure set", 32'(secure), 1);
    run_op(1'b1, 2'd0, 18'h0ABCD, 0, 2);
    run_op(1'b0, 2'd0, 18'h0ABCD, 0, 0);

    // R11 boot pin moves while running
    @(negedge clk);
    boot_pin = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 boot sel held", 32'(boot_map_sel), 0);
    check("R11 locks kept", 32'(lock_bits), 32'(exp_lock));
    check("R11 secure kept", 32'(secure), 1);

    // R7 wipe from debug port, with some locks set
    run_op(1'b0, 2'd3, 18'd2, 32'd1, 0);
    run_op(1'b0, 2'd3, 18'd15, 32'd1, 0);
    run_op(1'b1, 2'd3, 18'd16, 32'd0, 0);
    check("R7 first page", 32'(first_page), 0);
    check("R7 last page", 32'(last_page), NPAGES - 1);
    check("R7 ascending", 32'(seq_gap), 0);
    check("R7 all erase", n_prog, 0);

    // R4 and R3 region boundaries
    for (int k = 0; k < 16; k++) if (exp_lock[k]) run_op(1'b0, 2'd3, 18'(k), 32'd0, 0);
    run_op(1'b0, 2'd3, 18'd5, 32'd1, 0);
    run_op(1'b1, 2'd0, 18'h14123, 0, 0);
    run_op(1'b0, 2'd1, 18'h14000, 32'hDEAD, 0);
    run_op(1'b1, 2'd2, 18'h17FFF, 0, 0);
    check("R3 no strobe", n_strobe, 0);
    run_op(1'b0, 2'd1, 18'h18000, 32'hBEEF, 0);
    check("R6 program data", fl_wdata, 32'hBEEF);
    run_op(1'b1, 2'd2, 18'h13FFF, 0, 1);

    // R8 bad targets
    run_op(1'b0, 2'd3, 18'd17, 32'd1, 0);
    run_op(1'b1, 2'd3, 18'd31, 32'd0, 0);

    // R9 R10 wear on lock 7
    while (exp_cnt[7] < LIMIT - 1) run_op(1'b0, 2'd3, 18'd7, 32'(!exp_lock[7]), 0);
    check("R10 wear below limit", 32'(wear_flag), 0);
    for (int k = 0; k < 5; k++) run_op(k[0], 2'd3, 18'd7, 32'(exp_lock[7]), 0);
    check("R9 no count on repeat", 32'(wear_flag), 0);
    run_op(1'b0, 2'd3, 18'd7, 32'(!exp_lock[7]), 0);
    check("R10 wear at limit", 32'(wear_flag), 1);
    run_op(1'b0, 2'd3, 18'd7, 32'(!exp_lock[7]), 0);

    // R1 R11 reset with boot pin high
    do_reset(1'b1);
    @(negedge clk);
    check("R11 boot sel captured", 32'(boot_map_sel), 1);
    check("R1 locks after reset", 32'(lock_bits), 0);
    check("R1 secure after reset", 32'(secure), 0);
    check("R1 wear after reset", 32'(wear_flag), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule